// File: doc/BRIEF.md
# Working-Register Initialization and Illegal Opcode Trap

This block guards a processor core against two classes of programming error. It keeps one "initialized" bit for each entry of a 16-entry working-register file. It also screens every fetched instruction word for a reserved opcode pattern. When either error appears, it issues a single-cycle fault pulse that the system uses to request a device reset. At the same moment it sets a sticky status flag, so that start-up code can later find out why the reset happened.

A system reset clears every tracking bit except the one for register 15, the stack pointer, which always counts as initialized. Only a full-word load through one of the write ports marks a register initialized. Byte-wide writes never do, even when two of them together cover both halves of the register. A pointer-use strobe names the register that the core is about to dereference. If that register is still uninitialized, the fault fires.

A fault sequencer with three states controls the pulse:

- **ST_RUN** watches for faults.
- On a detected condition it moves from ST_RUN to **ST_PULSE**, which drives the fault strobe for exactly one cycle.
- It then always moves from ST_PULSE to **ST_HALT**, where further conditions are ignored.
- The only way out of ST_HALT back to ST_RUN is a reset.

The status flag lives in the power-on domain. It therefore survives the system reset that the fault itself triggers, and it is cleared only by the power-on reset.

Top module: `wreg_trap_detector`

## Requirements
- R1: While `rst_n` or `por_n` is low, `init_vec_o` equals 16'h8000 and `fault_o` is 0. A low `por_n` also clears `flag_o`.
- R2: A write with `wr_en[p]`=1 and `wr_word[p]`=1 (word) sets bit `wr_idx[p*4+:4]` of `init_vec_o`, visible from the next cycle. The bit then stays set until a reset.
- R3: A write with `wr_word[p]`=0 (byte) never sets a tracking bit, including two consecutive byte writes to the same register.
- R4: `ptr_en`=1 with `ptr_idx` naming a register whose `init_vec_o` bit is 0 raises `fault_o` in the next cycle. A word write to that register in the same cycle does not prevent the fault.
- R5: `fetch_valid`=1 with `fetch_word[23:16]`=8'h3F raises `fault_o` in the next cycle. Other upper-byte values such as 8'h3E or 8'h40, or `fetch_valid`=0, raise no fault.
- R6: Register 15 reads as initialized at all times, so a pointer use of index 15 never faults.
- R7: `fault_o` is high for exactly one cycle per fault. A pointer fault and an illegal fetch in the same cycle produce a single pulse.
- R8: After a pulse, further fault conditions produce no pulse until `rst_n` is pulsed low. After that, detection works again.
- R9: `flag_o` rises together with `fault_o`, stays at 1 through a low pulse on `rst_n`, and is cleared only by `por_n`.
- R10: The two write ports act independently. Word writes on both ports in one cycle mark both registers initialized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything including the flag |
| rst_n | input | 1 | System reset, active low, asynchronous; clears tracking and sequencer |
| wr_en | input | 2 | Write strobe per write port |
| wr_idx | input | 8 | Register index per port, 4 bits each, port p at [p*4+:4] |
| wr_word | input | 2 | Per port: 1 = full-word write, 0 = byte write |
| ptr_en | input | 1 | Register is used as an address pointer this cycle |
| ptr_idx | input | 4 | Index of the register used as a pointer |
| fetch_valid | input | 1 | A fetched instruction word is present |
| fetch_word | input | 24 | Fetched instruction word |
| fault_o | output | 1 | One-cycle fault pulse requesting a device reset |
| flag_o | output | 1 | Sticky illegal-opcode/uninitialized-register status flag |
| init_vec_o | output | 16 | Per-register initialized bits |

## Verification
The assertions assume a few things about the inputs:

- All inputs are free of X and change only between clock edges.
- Every register index lies inside the 16-entry file.
- Both resets are asserted at time zero.

The bench respects these assumptions. It drives every input on the falling edge, holds both resets low during its first cycles, and uses only 4-bit indices. The checks on the pointer fault and the illegal-fetch fault apply only while the sequencer is in ST_RUN. The bench therefore pulses `rst_n` before each table scenario, so that every vector starts from a clean tracking state.

// File: rtl/wreg_trap_pkg.sv
package wreg_trap_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_PULSE = 2'd1,
        ST_HALT  = 2'd2
    } trap_state_e;

endpackage

// File: rtl/wreg_init_tracker.sv
module wreg_init_tracker #(
    parameter int NUM_REGS   = 16,
    parameter int NUM_WR     = 2,
    parameter int EXEMPT_IDX = 15,
    localparam int IDX_W     = $clog2(NUM_REGS)
) (
    input  logic                    clk,
    input  logic                    sys_rst_n,
    input  logic [NUM_WR-1:0]       wr_en,
    input  logic [NUM_WR*IDX_W-1:0] wr_idx,
    input  logic [NUM_WR-1:0]       wr_word,
    input  logic                    ptr_en,
    input  logic [IDX_W-1:0]        ptr_idx,
    output logic [NUM_REGS-1:0]     init_vec,
    output logic                    ptr_fault
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        if (r == EXEMPT_IDX) begin : g_exempt
            assign init_vec[r] = 1'b1;
        end else begin : g_tracked
            logic set_hit;
            logic bit_q;

            always_comb begin
                set_hit = 1'b0;
                for (int p = 0; p < NUM_WR; p++) begin
                    if (wr_en[p] && wr_word[p] &&
                        (wr_idx[p*IDX_W +: IDX_W] == IDX_W'(r))) begin
                        set_hit = 1'b1;
                    end
                end
            end

            always_ff @(posedge clk or negedge sys_rst_n) begin
                if (!sys_rst_n) begin
                    bit_q <= 1'b0;
                end else if (set_hit) begin
                    bit_q <= 1'b1;
                end
            end

            assign init_vec[r] = bit_q;
        end
    end

    // The pointer check sees the state before this cycle's writes.
    assign ptr_fault = ptr_en && !init_vec[ptr_idx];

endmodule

// File: rtl/illegal_opcode_check.sv
module illegal_opcode_check #(
    parameter int             INSTR_W     = 24,
    parameter int             OPC_W       = 8,
    parameter logic [OPC_W-1:0] ILLEGAL_OPC = 8'h3F
) (
    input  logic               fetch_valid,
    input  logic [INSTR_W-1:0] fetch_word,
    output logic               opc_fault
);

    logic [OPC_W-1:0] upper_field;

    assign upper_field = fetch_word[INSTR_W-1 -: OPC_W];
    assign opc_fault   = fetch_valid && (upper_field == ILLEGAL_OPC);

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
    import wreg_trap_pkg::*;
(
    input  logic clk,
    input  logic sys_rst_n,
    input  logic por_n,
    input  logic hit,
    output logic fault_o,
    output logic flag_o,
    output logic run_o
);

    trap_state_e state_q;
    trap_state_e state_d;
    logic        flag_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (hit) state_d = ST_PULSE;
            ST_PULSE: state_d = ST_HALT;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag_q <= 1'b0;
        end else if (state_q == ST_RUN && hit) begin
            flag_q <= 1'b1;
        end
    end

    always_comb begin
        fault_o = (state_q == ST_PULSE);
        run_o   = (state_q == ST_RUN);
        flag_o  = flag_q;
    end

endmodule

// File: rtl/wreg_trap_detector.sv
module wreg_trap_detector #(
    parameter int               NUM_REGS    = 16,
    parameter int               NUM_WR      = 2,
    parameter int               EXEMPT_IDX  = 15,
    parameter int               INSTR_W     = 24,
    parameter int               OPC_W       = 8,
    parameter logic [OPC_W-1:0] ILLEGAL_OPC = 8'h3F,
    localparam int              IDX_W       = $clog2(NUM_REGS)
) (
    input  logic                    clk,
    input  logic                    por_n,
    input  logic                    rst_n,
    input  logic [NUM_WR-1:0]       wr_en,
    input  logic [NUM_WR*IDX_W-1:0] wr_idx,
    input  logic [NUM_WR-1:0]       wr_word,
    input  logic                    ptr_en,
    input  logic [IDX_W-1:0]        ptr_idx,
    input  logic                    fetch_valid,
    input  logic [INSTR_W-1:0]      fetch_word,
    output logic                    fault_o,
    output logic                    flag_o,
    output logic [NUM_REGS-1:0]     init_vec_o
);

    logic sys_rst_n;
    logic ptr_fault;
    logic opc_fault;
    logic run_q;

    assign sys_rst_n = rst_n & por_n;

    wreg_init_tracker #(
        .NUM_REGS   (NUM_REGS),
        .NUM_WR     (NUM_WR),
        .EXEMPT_IDX (EXEMPT_IDX)
    ) u_tracker (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_word   (wr_word),
        .ptr_en    (ptr_en),
        .ptr_idx   (ptr_idx),
        .init_vec  (init_vec_o),
        .ptr_fault (ptr_fault)
    );

    illegal_opcode_check #(
        .INSTR_W     (INSTR_W),
        .OPC_W       (OPC_W),
        .ILLEGAL_OPC (ILLEGAL_OPC)
    ) u_opc (
        .fetch_valid (fetch_valid),
        .fetch_word  (fetch_word),
        .opc_fault   (opc_fault)
    );

    trap_sequencer u_seq (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .por_n     (por_n),
        .hit       (ptr_fault | opc_fault),
        .fault_o   (fault_o),
        .flag_o    (flag_o),
        .run_o     (run_q)
    );

endmodule

// File: rtl/wreg_trap_checker.sv
module wreg_trap_checker #(
    parameter int               NUM_REGS    = 16,
    parameter int               INSTR_W     = 24,
    parameter int               OPC_W       = 8,
    parameter logic [OPC_W-1:0] ILLEGAL_OPC = 8'h3F,
    parameter int               EXEMPT_IDX  = 15,
    localparam int              IDX_W       = $clog2(NUM_REGS)
) (
    input logic                clk,
    input logic                por_n,
    input logic                rst_n,
    input logic                ptr_en,
    input logic [IDX_W-1:0]    ptr_idx,
    input logic                fetch_valid,
    input logic [INSTR_W-1:0]  fetch_word,
    input logic                fault_o,
    input logic                flag_o,
    input logic [NUM_REGS-1:0] init_vec_o,
    input logic                run_q
);

    logic sys_ok;
    assign sys_ok = rst_n & por_n;

    a_r1_reset_state: assert property (@(posedge clk)
        !sys_ok |-> (init_vec_o == NUM_REGS'(1) << EXEMPT_IDX) && !fault_o);

    a_r2_bits_sticky: assert property (@(posedge clk) disable iff (!sys_ok)
        1'b1 |=> ((init_vec_o & $past(init_vec_o)) == $past(init_vec_o)));

    a_r4_ptr_fault: assert property (@(posedge clk) disable iff (!sys_ok)
        (run_q && ptr_en && !init_vec_o[ptr_idx]) |=> fault_o);

    a_r5_opc_fault: assert property (@(posedge clk) disable iff (!sys_ok)
        (run_q && fetch_valid && fetch_word[INSTR_W-1 -: OPC_W] == ILLEGAL_OPC) |=> fault_o);

    a_r6_exempt_set: assert property (@(posedge clk) disable iff (!sys_ok)
        init_vec_o[EXEMPT_IDX]);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!sys_ok)
        fault_o |=> !fault_o);

    a_r9_flag_with_fault: assert property (@(posedge clk) disable iff (!por_n)
        fault_o |-> flag_o);

endmodule

bind wreg_trap_detector wreg_trap_checker #(
    .NUM_REGS    (NUM_REGS),
    .INSTR_W     (INSTR_W),
    .OPC_W       (OPC_W),
    .ILLEGAL_OPC (ILLEGAL_OPC),
    .EXEMPT_IDX  (EXEMPT_IDX)
) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .rst_n       (rst_n),
    .ptr_en      (ptr_en),
    .ptr_idx     (ptr_idx),
    .fetch_valid (fetch_valid),
    .fetch_word  (fetch_word),
    .fault_o     (fault_o),
    .flag_o      (flag_o),
    .init_vec_o  (init_vec_o),
    .run_q       (run_q)
);

// File: tb/wreg_trap_detector_bench.sv
`timescale 1ns/1ps
module wreg_trap_detector_bench;

    localparam int CYC = 4;

    logic        clk = 1'b0;
    logic        por_n, rst_n;
    logic [1:0]  wr_en, wr_word;
    logic [7:0]  wr_idx;
    logic        ptr_en, fetch_valid;
    logic [3:0]  ptr_idx;
    logic [23:0] fetch_word;
    logic        fault_o, flag_o;
    logic [15:0] init_vec_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CYC/2) clk = ~clk;

    wreg_trap_detector u_wreg_trap_detector (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
        .ptr_en(ptr_en), .ptr_idx(ptr_idx),
        .fetch_valid(fetch_valid), .fetch_word(fetch_word),
        .fault_o(fault_o), .flag_o(flag_o), .init_vec_o(init_vec_o)
    );

    typedef struct packed {
        logic       w_en;
        logic       w_word;
        logic [3:0] w_idx;
        logic       p_en;
        logic [3:0] p_idx;
        logic       f_en;
        logic [7:0] f_hi;
        logic       exp_fault;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 4'd3,  1'b1, 4'd3,  1'b0, 8'h00, 1'b0},
        '{1'b1, 1'b0, 4'd3,  1'b1, 4'd3,  1'b0, 8'h00, 1'b1},
        '{1'b0, 1'b0, 4'd0,  1'b1, 4'd15, 1'b0, 8'h00, 1'b0},
        '{1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 8'h3F, 1'b1},
        '{1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 8'h3E, 1'b0},
        '{1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 8'h40, 1'b0},
        '{1'b1, 1'b1, 4'd0,  1'b1, 4'd1,  1'b0, 8'h00, 1'b1},
        '{1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 8'h3F, 1'b0},
        '{1'b1, 1'b1, 4'd15, 1'b1, 4'd15, 1'b0, 8'h00, 1'b0},
        '{1'b1, 1'b1, 4'd7,  1'b0, 4'd0,  1'b1, 8'h3F, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        wr_en = '0; wr_word = '0; wr_idx = '0;
        ptr_en = 1'b0; ptr_idx = '0;
        fetch_valid = 1'b0; fetch_word = '0;
    endtask

    task automatic sys_reset();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        #(CYC * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        por_n = 1'b0;
        rst_n = 1'b0;
        step();
        step();
        // R1 reset state while held
        check("R1 init_vec in reset", 32'(init_vec_o), 32'h8000);
        check("R1 fault in reset", 32'(fault_o), 0);
        check("R1 flag after por", 32'(flag_o), 0);
        por_n = 1'b1;
        rst_n = 1'b1;
        step();

        // Table walk (R2 R3 R4 R5 R6)
        for (int i = 0; i < NV; i++) begin
            logic [15:0] exp_vec;
            sys_reset();
            wr_en[0]   = VECS[i].w_en;
            wr_word[0] = VECS[i].w_word;
            wr_idx[3:0] = VECS[i].w_idx;
            step();
            idle_inputs();
            exp_vec = 16'h8000;
            if (VECS[i].w_en && VECS[i].w_word) exp_vec[VECS[i].w_idx] = 1'b1;
            check($sformatf("R2/R3 init_vec vec%0d", i), 32'(init_vec_o), 32'(exp_vec));
            ptr_en      = VECS[i].p_en;
            ptr_idx     = VECS[i].p_idx;
            fetch_valid = VECS[i].f_en;
            fetch_word  = {VECS[i].f_hi, 16'h1234};
            step();
            idle_inputs();
            check($sformatf("R4/R5/R6 fault vec%0d", i), 32'(fault_o), 32'(VECS[i].exp_fault));
            step();
            check($sformatf("R7 pulse ends vec%0d", i), 32'(fault_o), 0);
        end

        // R3: two consecutive byte writes to r5 on different halves
        sys_reset();
        wr_en[0] = 1'b1; wr_word[0] = 1'b0; wr_idx[3:0] = 4'd5;
        step();
        step();
        idle_inputs();
        check("R3 two byte writes", 32'(init_vec_o[5]), 0);
        ptr_en = 1'b1; ptr_idx = 4'd5;
        step();
        idle_inputs();
        check("R3 ptr after byte writes faults", 32'(fault_o), 1);

        // R4: same-cycle word write and pointer use still faults
        sys_reset();
        wr_en[1] = 1'b1; wr_word[1] = 1'b1; wr_idx[7:4] = 4'd9;
        ptr_en = 1'b1; ptr_idx = 4'd9;
        step();
        idle_inputs();
        check("R4 same-cycle write no bypass", 32'(fault_o), 1);
        check("R4 write still recorded", 32'(init_vec_o[9]), 1);

        // R10: both ports word writes same cycle
        sys_reset();
        wr_en = 2'b11; wr_word = 2'b11; wr_idx = {4'd2, 4'd1};
        step();
        idle_inputs();
        check("R10 dual-port init", 32'(init_vec_o), 32'h8006);

        // R2: bits persist over idle cycles, reset clears them
        for (int k = 0; k < 5; k++) step();
        check("R2 bits persist", 32'(init_vec_o), 32'h8006);
        ptr_en = 1'b1; ptr_idx = 4'd2;
        step();
        idle_inputs();
        check("R2 initialized ptr no fault", 32'(fault_o), 0);
        sys_reset();
        check("R2/R1 reset clears bits", 32'(init_vec_o), 32'h8000);

        // R7: both conditions in one cycle -> one pulse
        ptr_en = 1'b1; ptr_idx = 4'd4;
        fetch_valid = 1'b1; fetch_word = 24'h3F0000;
        step();
        idle_inputs();
        check("R7 simultaneous pulse", 32'(fault_o), 1);
        step();
        check("R7 pulse one cycle", 32'(fault_o), 0);

        // R8: conditions ignored in halt state
        fetch_valid = 1'b1; fetch_word = 24'h3FFFFF;
        ptr_en = 1'b1; ptr_idx = 4'd6;
        step();
        check("R8 halted no pulse 1", 32'(fault_o), 0);
        step();
        idle_inputs();
        check("R8 halted no pulse 2", 32'(fault_o), 0);

        // R9: flag survives rst_n, re-arm works after rst_n
        check("R9 flag set", 32'(flag_o), 1);
        sys_reset();
        check("R9 flag kept over rst_n", 32'(flag_o), 1);
        fetch_valid = 1'b1; fetch_word = 24'h3F0001;
        step();
        idle_inputs();
        check("R8 re-armed after reset", 32'(fault_o), 1);
        por_n = 1'b0;
        step();
        check("R9 flag cleared by por_n", 32'(flag_o), 0);
        check("R1 por clears init_vec", 32'(init_vec_o), 32'h8000);
        por_n = 1'b1;
        step();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule